// File: doc/BRIEF.md
# Asynchronous HDLC Receive Frame Closer

This block sits behind a byte-level asynchronous HDLC receiver. The receiver has already removed start and stop bits. The block watches each received octet together with the carrier-detect level, a break indication, the CRC checker's verdict and a mode input. From these it decides when the current receive frame ends and which single error flag, if any, the closing buffer descriptor carries. Data octets of an open frame go into an internal byte queue. The descriptor writer drains that queue through a show-ahead read port.

A frame opens on a flag octet. It ends on a later flag, on an abort pair, on a break, on a queue overflow or on loss of carrier. Each ending gives a one-cycle close strobe. The status vector is then held for the descriptor writer, and a frame-done event follows one cycle later. After a close, the block hunts for a fresh opening flag. After carrier loss, it waits for carrier first.

Top module: `hdlc_rx_err_handler`

## Requirements
- R1: Data octets of an open frame (neither flags nor the second octet of an abort pair) enter a FIFO_DEPTH-entry queue (default 16) in arrival order. `fifo_data` shows the oldest entry, `fifo_pop` removes it, and a pop while `fifo_empty` is high has no effect.
- R2: A data octet that arrives while the queue is full, with no pop in the same cycle, is dropped. The frame closes with status bit 1 (overrun), and the block returns to hunting, so octets that follow without a new opening flag are not queued.
- R3: If `cd_in` is low while a frame is open, the frame closes with only status bit 0 (carrier lost), whatever else happens in that cycle. The octet of that cycle and every later octet of the frame are discarded.
- R4: After a carrier-lost close, and whenever `cd_in` is low, all octets are ignored. Once `cd_in` is high again, only a new opening flag (0x7E) starts a frame.
- R5: An abort is 0x7D followed directly by 0x7E when `irlap_mode` is 0, or by 0xC1 when `irlap_mode` is 1. Inside a frame it closes the frame with status bit 2, and `crc_ok` is ignored. The 0x7D stays queued and the second octet is not queued. In mode 1, 0x7D followed by 0x7E is an ordinary flag.
- R6: An abort pair that arrives while hunting still produces one close strobe, with only status bit 2 set.
- R7: A flag (0x7E) after at least one queued data octet ends the frame. With `crc_ok` high the status is zero; with `crc_ok` low it is status bit 4 (CRC error). Either way the queued octets, including the received CRC octets, remain in the queue. Flags with no data octet between them are idle fill and close nothing.
- R8: A `rx_break` pulse while a frame is open closes it with status bit 3, and the CRC verdict is ignored. Outside a frame the pulse has no effect.
- R9: When several closing causes meet in one cycle, exactly one status bit is set, in the order carrier lost, overrun, abort, break, CRC error.
- R10: `close_stb` is a one-cycle pulse in the cycle after the clock edge that sampled the closing condition. It occurs once per frame, and `frame_done` pulses in the cycle after it.
- R11: `close_status` holds its value from the close strobe until the next opening flag is accepted, and then returns to zero.
- R12: After reset, `close_stb`, `frame_done` and `close_status` are zero, the queue is empty and the block is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received octet strobe |
| rx_byte | input | 8 | Received octet |
| rx_break | input | 1 | First character of a break detected |
| cd_in | input | 1 | Carrier-detect level, high when the carrier is present |
| crc_ok | input | 1 | CRC verdict, valid with a flag octet |
| irlap_mode | input | 1 | Abort code select: 0 gives 0x7D 0x7E, 1 gives 0x7D 0xC1 |
| fifo_pop | input | 1 | Remove the oldest queued octet |
| fifo_data | output | 8 | Oldest queued octet |
| fifo_empty | output | 1 | Queue is empty |
| close_stb | output | 1 | Buffer close strobe |
| close_status | output | 5 | Bit 0 carrier lost, 1 overrun, 2 abort, 3 break, 4 CRC error |
| frame_done | output | 1 | Frame-done event, one cycle after the close |

## Verification
The abort detector is swept over all 256 octet values that can follow 0x7D, in both modes. Each pass shows whether a value aborts, ends the frame as a flag, re-arms the escape, or is queued as data. Targeted sequences then separate good frames from CRC-error frames and idle flags, and show overrun against a queue that is only nearly full. They also cover carrier loss with the octets lost while the carrier is down, and aborts and breaks inside a frame against those outside one. A final set raises several causes in the same cycle to show that only the highest-ranked flag appears.

// File: rtl/hdlc_rxerr_pkg.sv
`timescale 1ns/1ps
package hdlc_rxerr_pkg;
   localparam int NCAUSE  = 5;
   localparam int IDX_CDL = 0;
   localparam int IDX_OV  = 1;
   localparam int IDX_AB  = 2;
   localparam int IDX_BRK = 3;
   localparam int IDX_CR  = 4;

   localparam logic [7:0] FLAG_OCTET   = 8'h7E;
   localparam logic [7:0] ESC_OCTET    = 8'h7D;
   localparam logic [7:0] ABORT_PPP    = 8'h7E;
   localparam logic [7:0] ABORT_IRLAP  = 8'hC1;

   typedef enum logic [1:0] {
      ST_HUNT   = 2'd0,
      ST_FRAME  = 2'd1,
      ST_CDWAIT = 2'd2
   } rx_state_e;
endpackage

// File: rtl/hdlc_rxerr_fifo.sv
`timescale 1ns/1ps
module hdlc_rxerr_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wr_data,
   input  logic         pop,
   output logic [W-1:0] rd_data,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2 = (DEPTH == (1 << AW));

   if (DEPTH < 2) begin : g_bad_depth
      $error("hdlc_rxerr_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hdlc_rxerr_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [AW:0]   cnt;
   logic          do_pop, do_push;

   if (POW2) begin : g_wrap_natural
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_compare
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   assign full    = (cnt == (AW+1)'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assert_pop_counts_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty && !push) |=> (cnt == ($past(cnt) - 1'b1)));
   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/hdlc_rxerr_prio.sv
`timescale 1ns/1ps
module hdlc_rxerr_prio #(
   parameter int N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   if (N < 1) begin : g_bad_n
      $error("hdlc_rxerr_prio: N must be positive");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (i == 0) begin : g_top
         assign grant[i] = req[i];
      end else begin : g_rest
         assign grant[i] = req[i] & ~(|req[i-1:0]);
      end
   end

   assign any = |req;
endmodule

// File: rtl/hdlc_rxerr_classify.sv
`timescale 1ns/1ps
module hdlc_rxerr_classify
   import hdlc_rxerr_pkg::*;
(
   input  logic [7:0] octet,
   input  logic       esc_pend,
   input  logic       irlap,
   output logic       is_esc,
   output logic       is_abort,
   output logic       is_flag
);
   logic [7:0] abort_code;

   assign abort_code = irlap ? ABORT_IRLAP : ABORT_PPP;
   assign is_esc     = (octet == ESC_OCTET);
   assign is_abort   = esc_pend && (octet == abort_code);
   assign is_flag    = (octet == FLAG_OCTET) && !is_abort;
endmodule

// File: rtl/hdlc_rx_err_handler.sv
`timescale 1ns/1ps
module hdlc_rx_err_handler
   import hdlc_rxerr_pkg::*;
#(
   parameter int FIFO_DEPTH = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   input  logic       rx_break,
   input  logic       cd_in,
   input  logic       crc_ok,
   input  logic       irlap_mode,
   input  logic       fifo_pop,
   output logic [7:0] fifo_data,
   output logic       fifo_empty,
   output logic       close_stb,
   output logic [4:0] close_status,
   output logic       frame_done
);
   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("hdlc_rx_err_handler: FIFO_DEPTH must be at least 2");
   end

   rx_state_e         st;
   logic              esc_q, have_data_q, close_q, done_q;
   logic [NCAUSE-1:0] status_q, req, grant;
   logic              any_req;
   logic              is_esc, is_abort, is_flag;
   logic              fifo_full, push;
   logic              in_frame, in_hunt, byte_ev, data_byte;
   logic              good_end, close_now, open_now;

   hdlc_rxerr_classify u_cls (
      .octet    (rx_byte),
      .esc_pend (esc_q),
      .irlap    (irlap_mode),
      .is_esc   (is_esc),
      .is_abort (is_abort),
      .is_flag  (is_flag)
   );

   assign in_frame  = (st == ST_FRAME);
   assign in_hunt   = (st == ST_HUNT);
   assign byte_ev   = rx_valid && cd_in && (st != ST_CDWAIT);
   assign data_byte = byte_ev && !is_flag && !is_abort;

   always_comb begin
      req          = '0;
      req[IDX_CDL] = in_frame && !cd_in;
      req[IDX_OV]  = in_frame && data_byte && fifo_full && !fifo_pop;
      req[IDX_AB]  = byte_ev && is_abort;
      req[IDX_BRK] = in_frame && rx_break;
      req[IDX_CR]  = in_frame && byte_ev && is_flag && have_data_q && !crc_ok;
   end

   hdlc_rxerr_prio #(.N(NCAUSE)) u_prio (
      .req   (req),
      .grant (grant),
      .any   (any_req)
   );

   assign good_end  = in_frame && byte_ev && is_flag && have_data_q && crc_ok;
   assign close_now = any_req || good_end;
   assign open_now  = in_hunt && byte_ev && is_flag;
   assign push      = in_frame && data_byte && !close_now;

   hdlc_rxerr_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .wr_data (rx_byte),
      .pop     (fifo_pop),
      .rd_data (fifo_data),
      .full    (fifo_full),
      .empty   (fifo_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_HUNT;
         esc_q       <= 1'b0;
         have_data_q <= 1'b0;
         status_q    <= '0;
         close_q     <= 1'b0;
         done_q      <= 1'b0;
      end else begin
         close_q <= close_now;
         done_q  <= close_q;

         case (st)
            ST_HUNT: begin
               if (!cd_in)        st <= ST_CDWAIT;
               else if (open_now) st <= ST_FRAME;
            end
            ST_FRAME: begin
               if (req[IDX_CDL])   st <= ST_CDWAIT;
               else if (close_now) st <= ST_HUNT;
            end
            default: begin
               if (cd_in) st <= ST_HUNT;
            end
         endcase

         if (open_now)  have_data_q <= 1'b0;
         else if (push) have_data_q <= 1'b1;

         if (close_now)     status_q <= grant;
         else if (open_now) status_q <= '0;

         if (close_now || !cd_in) esc_q <= 1'b0;
         else if (byte_ev)        esc_q <= is_esc;
      end
   end

   assign close_stb    = close_q;
   assign close_status = status_q;
   assign frame_done   = done_q;

   assert_cdl_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && !cd_in) |=> (close_stb && close_status == 5'b00001));
   assert_cdwait_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CDWAIT) |=> !close_stb);
   assert_abort_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_ev && is_abort) |=> (close_stb && close_status[IDX_AB]));
   assert_one_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      close_stb |-> $onehot0(close_status));
   assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      close_stb |=> frame_done);
   assert_done_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(close_stb));
   assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (close_stb && !open_now && !close_now) |=> $stable(close_status));
endmodule

// File: tb/hdlc_rx_err_handler_test.sv
`timescale 1ns/1ps
module hdlc_rx_err_handler_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       rx_break = 1'b0;
   logic       cd_in = 1'b1;
   logic       crc_ok = 1'b0;
   logic       irlap_mode = 1'b0;
   logic       fifo_pop = 1'b0;
   logic [7:0] fifo_data;
   logic       fifo_empty;
   logic       close_stb;
   logic [4:0] close_status;
   logic       frame_done;

   int         n_cmp = 0;
   int         n_bad = 0;
   logic       seen_close;
   logic [4:0] seen_status;
   logic [7:0] got[$];

   always #2.5 clk = ~clk;

   hdlc_rx_err_handler uut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_break(rx_break), .cd_in(cd_in), .crc_ok(crc_ok),
      .irlap_mode(irlap_mode), .fifo_pop(fifo_pop), .fifo_data(fifo_data),
      .fifo_empty(fifo_empty), .close_stb(close_stb),
      .close_status(close_status), .frame_done(frame_done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic v, input logic [7:0] b, input logic crc, input logic brk);
      rx_valid = v; rx_byte = b; crc_ok = crc; rx_break = brk;
      @(negedge clk);
      seen_close  = close_stb;
      seen_status = close_status;
      rx_valid = 1'b0; crc_ok = 1'b0; rx_break = 1'b0;
   endtask

   task automatic put(input logic [7:0] b);
      cyc(1'b1, b, 1'b0, 1'b0);
   endtask

   task automatic drain();
      got.delete();
      for (int k = 0; k < 64 && !fifo_empty; k++) begin
         got.push_back(fifo_data);
         fifo_pop = 1'b1;
         @(negedge clk);
         fifo_pop = 1'b0;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12 close_stb", close_stb, 0);
      chk("R12 frame_done", frame_done, 0);
      chk("R12 status", close_status, 0);
      chk("R12 fifo_empty", fifo_empty, 1);
      // R1 pop on empty has no effect
      fifo_pop = 1'b1; @(negedge clk); fifo_pop = 1'b0;
      chk("R1 pop empty", fifo_empty, 1);

      // R7 idle flags then good frame
      put(8'h7E); put(8'h7E); put(8'h7E);
      chk("R7 idle flags no close", seen_close, 0);
      put(8'hA1); put(8'hB2); put(8'hC3);
      chk("R7 data no close", seen_close, 0);
      cyc(1'b1, 8'h7E, 1'b1, 1'b0);
      chk("R7 good close", seen_close, 1);
      chk("R7 good status", seen_status, 0);
      @(negedge clk);
      chk("R10 frame_done", frame_done, 1);
      chk("R10 single strobe", close_stb, 0);
      drain();
      chk("R1 count", got.size(), 3);
      if (got.size() == 3) begin
         chk("R1 order0", got[0], 8'hA1);
         chk("R1 order1", got[1], 8'hB2);
         chk("R1 order2", got[2], 8'hC3);
      end

      // R7 CRC error, R11 hold
      put(8'h7E); put(8'h55); put(8'h66);
      cyc(1'b1, 8'h7E, 1'b0, 1'b0);
      chk("R7 crc close", seen_close, 1);
      chk("R7 crc status", seen_status, 5'b10000);
      put(8'h44); @(negedge clk);
      chk("R11 status held", close_status, 5'b10000);
      drain();
      chk("R7 crc octets kept", got.size(), 2);
      put(8'h7E);
      chk("R11 cleared on open", seen_status, 0);
      put(8'h01); cyc(1'b1, 8'h7E, 1'b1, 1'b0);
      chk("R7 close after reopen", seen_close, 1);
      drain();

      // R5 abort sweep over the octet after 0x7D
      for (int m = 0; m < 2; m++) begin
         irlap_mode = m[0];
         for (int v = 0; v < 256; v++) begin
            logic [7:0] code, vb, exp_last;
            logic [4:0] exp_st;
            int exp_n;
            code = (m == 1) ? 8'hC1 : 8'h7E;
            vb = v[7:0];
            put(8'h7E); put(8'h11); put(8'h7D);
            cyc(1'b1, vb, 1'b0, 1'b0);
            if (vb == code) begin
               exp_st = 5'b00100; exp_n = 2;
               chk("R5 abort close", seen_close, 1);
            end else if (m == 1 && vb == 8'h7E) begin
               exp_st = 5'b10000; exp_n = 2;
               chk("R5 irlap flag close", seen_close, 1);
            end else begin
               chk("R5 data no close", seen_close, 0);
               cyc(1'b1, 8'h7E, 1'b1, 1'b0);
               exp_st = (m == 0 && vb == 8'h7D) ? 5'b00100 : 5'b00000;
               exp_n = 3;
               chk("R5 end close", seen_close, 1);
            end
            chk("R5 status", seen_status, exp_st);
            drain();
            exp_last = (exp_n == 3) ? vb : 8'h7D;
            chk("R5 queued count", got.size(), exp_n);
            if (got.size() == exp_n) chk("R5 last queued", got[exp_n-1], exp_last);
         end
      end

      // R6 abort while hunting
      irlap_mode = 1'b0;
      put(8'h7D);
      chk("R6 esc alone", seen_close, 0);
      put(8'h7E);
      chk("R6 ppp hunt abort", seen_close, 1);
      chk("R6 ppp status", seen_status, 5'b00100);
      @(negedge clk);
      chk("R10 done after hunt abort", frame_done, 1);
      chk("R11 abort held", close_status, 5'b00100);
      irlap_mode = 1'b1;
      put(8'h7D); put(8'hC1);
      chk("R6 irlap hunt abort", seen_close, 1);
      chk("R6 irlap status", seen_status, 5'b00100);
      irlap_mode = 1'b0;
      put(8'h7D); put(8'h41);
      chk("R6 non-abort pair", seen_close, 0);
      chk("R4 hunt ignores data", fifo_empty, 1);

      // R2 overrun
      put(8'h7E);
      for (int i = 0; i < 16; i++) put(8'(i + 8'h20));
      chk("R2 full no close", seen_close, 0);
      put(8'hEE);
      chk("R2 overrun close", seen_close, 1);
      chk("R2 overrun status", seen_status, 5'b00010);
      put(8'h99);
      chk("R2 hunting after", seen_close, 0);
      drain();
      chk("R2 queued count", got.size(), 16);
      begin
         int bad = 0;
         for (int i = 0; i < got.size(); i++) if (got[i] != 8'(i + 8'h20)) bad++;
         chk("R2 queued values", bad, 0);
      end

      // R3 / R4 carrier loss
      put(8'h7E); put(8'h21);
      cd_in = 1'b0;
      cyc(1'b1, 8'h22, 1'b0, 1'b1);
      chk("R3 cd close", seen_close, 1);
      chk("R3 cd status only", seen_status, 5'b00001);
      put(8'h7E); put(8'h23);
      chk("R4 no close while down", seen_close, 0);
      cd_in = 1'b1;
      @(negedge clk);
      put(8'h24);
      chk("R4 no frame without flag", seen_close, 0);
      put(8'h7E); put(8'h25); cyc(1'b1, 8'h7E, 1'b1, 1'b0);
      chk("R4 new frame close", seen_status, 0);
      drain();
      chk("R3 discarded count", got.size(), 2);
      if (got.size() == 2) begin
         chk("R3 kept first", got[0], 8'h21);
         chk("R4 kept after flag", got[1], 8'h25);
      end
      cd_in = 1'b0; @(negedge clk);
      chk("R4 cd low hunting no close", close_stb, 0);
      cd_in = 1'b1; @(negedge clk);

      // R8 break
      cyc(1'b0, 8'h00, 1'b0, 1'b1);
      chk("R8 break outside frame", seen_close, 0);
      put(8'h7E); put(8'h31);
      cyc(1'b0, 8'h00, 1'b0, 1'b1);
      chk("R8 break close", seen_close, 1);
      chk("R8 break status", seen_status, 5'b01000);
      put(8'h7E); put(8'h32);
      cyc(1'b1, 8'h7E, 1'b0, 1'b1);
      chk("R9 break over crc", seen_status, 5'b01000);
      drain();

      // R9 coincidences
      put(8'h7E);
      for (int i = 0; i < 16; i++) put(8'h40);
      cyc(1'b1, 8'h41, 1'b0, 1'b1);
      chk("R9 overrun over break", seen_status, 5'b00010);
      drain();
      put(8'h7E);
      for (int i = 0; i < 16; i++) put(8'h50);
      cd_in = 1'b0;
      cyc(1'b1, 8'h51, 1'b0, 1'b1);
      chk("R9 carrier over all", seen_status, 5'b00001);
      cd_in = 1'b1; @(negedge clk);
      drain();
      put(8'h7E); put(8'h61); put(8'h7D);
      cyc(1'b1, 8'h7E, 1'b0, 1'b1);
      chk("R9 abort over break", seen_status, 5'b00100);
      drain();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule